// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns a bus address into active-low chip selects for two memory windows. One is a lower window. It starts at address zero, and its size is a power of two. The other is a midrange window. Its base and power-of-two size are both set in configuration, and it is cut into four equal regions, each with a select line of its own. A select asserts only when a bus cycle is marked valid, the bus is not in hold, the window is enabled and the address falls inside the window. If the two windows overlap, the lower window takes priority.

The last midrange select pin doubles as a refresh strobe output. When the DRAM mode bit is set, that pin carries the inverted refresh request instead of the region-3 select. The refresh strobe keeps running during bus hold. All outputs are registered, so each one changes only at a rising clock edge.

Top module: `memcs_decoder`

## Requirements
- R1: While `rst` is high, and at the first rising edge after it, `low_sel_n` and all four `mid_sel_n` bits are 1. This holds even when DRAM mode is on and a refresh is requested.
- R2: The lower window covers addresses 0 to 2^L − 1, where L is the effective lower size code. `low_sel_n` is 0 only when `cfg_low_en`=1, `addr_vld`=1, `bus_hold`=0 and the address lies in that range.
- R3: A size code below its minimum is treated as the minimum, and a code above its maximum is treated as the maximum. The lower window clamps to 10..19 (1 KB to 512 KB) and the midrange window clamps to 13..19.
- R4: The midrange window of size 2^M holds the address when addr>>M equals cfg_mid_base>>M, so base bits below M are ignored. The region is addr bits [M−1:M−2]. Region k drives `mid_sel_n[k]` low, and only that bit.
- R5: When an address lies in both windows, `low_sel_n` goes low and every midrange select stays high.
- R6: While `bus_hold`=1, `low_sel_n` and the midrange selects are 1. The exception is bit 3 in DRAM mode, which follows R7.
- R7: With `cfg_dram_en`=1, `mid_sel_n[3]` equals the inverse of `rfsh_req`, regardless of address, valid or hold, and a region-3 hit does not drive it low.
- R8: When `cfg_low_en`=0 the lower select never asserts. When `cfg_mid_en`=0 no midrange select asserts.
- R9: At most one of `low_sel_n`, `mid_sel_n[2:0]` is 0 at any time. `mid_sel_n[3]` is also included in this count when DRAM mode is off.
- R10: When `addr_vld`=0, no select is asserted.
- R11: The outputs reflect the inputs sampled at the previous rising edge. A change in the inputs between two edges does not move the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Bus address |
| addr_vld | input | 1 | Bus cycle valid |
| bus_hold | input | 1 | Bus granted away; gates all selects |
| cfg_low_en | input | 1 | Lower window enable |
| cfg_low_size_l2 | input | L2_W | Lower window size as log2 of bytes |
| cfg_mid_en | input | 1 | Midrange window enable |
| cfg_mid_base | input | ADDR_W | Midrange window base |
| cfg_mid_size_l2 | input | L2_W | Midrange window size as log2 of bytes |
| cfg_dram_en | input | 1 | Gives pin 3 to the refresh strobe |
| rfsh_req | input | 1 | Refresh strobe request, active high |
| low_sel_n | output | 1 | Lower window select, active low |
| mid_sel_n | output | 4 | Midrange region selects, active low; bit 3 shared with refresh |

## Verification
The bench uses the default parameters: a 20-bit address, a lower size range of 10..19 and a midrange size range of 13..19. With these values the 512 KB lower boundary (0x7FFFF against 0x80000) and the 1 KB floor can both be reached, and so can the clamping of out-of-range size codes on both windows. The widest 512 KB midrange window lands in the upper half of the address space, so its region index comes from address bits 18:17. A misaligned midrange base shows that the base bits below the size are masked off.

// File: rtl/memcs_pkg.sv
package memcs_pkg;
  localparam int NUM_MID = 4;
  localparam int RGN_W   = $clog2(NUM_MID);

  typedef enum logic {
    PIN3_SELECT  = 1'b0,
    PIN3_REFRESH = 1'b1
  } pin3_mode_e;
endpackage

// File: rtl/memcs_win_low.sv
module memcs_win_low #(
  parameter int ADDR_W = 20,
  parameter int L2_W   = 5,
  parameter int MIN_L2 = 10,
  parameter int MAX_L2 = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic [L2_W-1:0]   size_l2,
  output logic              hit
);
  localparam logic [L2_W-1:0] LO = L2_W'(MIN_L2);
  localparam logic [L2_W-1:0] HI = L2_W'(MAX_L2);

  logic [L2_W-1:0] eff_l2;

  always_comb begin
    if (size_l2 < LO)      eff_l2 = LO;
    else if (size_l2 > HI) eff_l2 = HI;
    else                   eff_l2 = size_l2;
    hit = en && ((addr >> eff_l2) == '0);
  end
endmodule

// File: rtl/memcs_win_mid.sv
module memcs_win_mid
  import memcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int L2_W   = 5,
  parameter int MIN_L2 = 13,
  parameter int MAX_L2 = 19
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               en,
  input  logic [ADDR_W-1:0]  base,
  input  logic [L2_W-1:0]    size_l2,
  output logic [NUM_MID-1:0] rgn_hit
);
  localparam logic [L2_W-1:0] LO  = L2_W'(MIN_L2);
  localparam logic [L2_W-1:0] HI  = L2_W'(MAX_L2);
  localparam logic [L2_W-1:0] SUB = L2_W'(RGN_W);

  logic [L2_W-1:0]  eff_l2;
  logic             win_hit;
  logic [RGN_W-1:0] idx;

  always_comb begin
    if (size_l2 < LO)      eff_l2 = LO;
    else if (size_l2 > HI) eff_l2 = HI;
    else                   eff_l2 = size_l2;
    win_hit = en && (((addr ^ base) >> eff_l2) == '0);
    idx     = RGN_W'(addr >> (eff_l2 - SUB));
  end

  for (genvar g = 0; g < NUM_MID; g++) begin : g_rgn
    assign rgn_hit[g] = win_hit && (idx == RGN_W'(g));
  end
endmodule

// File: rtl/memcs_decoder.sv
module memcs_decoder
  import memcs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int L2_W       = 5,
  parameter int LOW_MIN_L2 = 10,
  parameter int LOW_MAX_L2 = 19,
  parameter int MID_MIN_L2 = 13,
  parameter int MID_MAX_L2 = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_vld,
  input  logic              bus_hold,
  input  logic              cfg_low_en,
  input  logic [L2_W-1:0]   cfg_low_size_l2,
  input  logic              cfg_mid_en,
  input  logic [ADDR_W-1:0] cfg_mid_base,
  input  logic [L2_W-1:0]   cfg_mid_size_l2,
  input  logic              cfg_dram_en,
  input  logic              rfsh_req,
  output logic              low_sel_n,
  output logic [3:0]        mid_sel_n
);
  logic               low_hit;
  logic [NUM_MID-1:0] mid_hit;
  logic               go;
  logic               low_q;
  logic [NUM_MID-1:0] mid_q;
  logic [NUM_MID-1:0] mid_d;
  pin3_mode_e         pin3_mode;

  memcs_win_low #(
    .ADDR_W(ADDR_W), .L2_W(L2_W), .MIN_L2(LOW_MIN_L2), .MAX_L2(LOW_MAX_L2)
  ) u_low (
    .addr(addr), .en(cfg_low_en), .size_l2(cfg_low_size_l2), .hit(low_hit)
  );

  memcs_win_mid #(
    .ADDR_W(ADDR_W), .L2_W(L2_W), .MIN_L2(MID_MIN_L2), .MAX_L2(MID_MAX_L2)
  ) u_mid (
    .addr(addr), .en(cfg_mid_en), .base(cfg_mid_base),
    .size_l2(cfg_mid_size_l2), .rgn_hit(mid_hit)
  );

  assign go        = addr_vld && !bus_hold;
  assign pin3_mode = cfg_dram_en ? PIN3_REFRESH : PIN3_SELECT;

  always_comb begin
    for (int i = 0; i < NUM_MID; i++)
      mid_d[i] = !(go && !low_hit && mid_hit[i]);
    if (pin3_mode == PIN3_REFRESH)
      mid_d[NUM_MID-1] = !rfsh_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= 1'b1;
      mid_q <= '1;
    end else begin
      low_q <= !(go && low_hit);
      mid_q <= mid_d;
    end
  end

  assign low_sel_n = low_q;
  assign mid_sel_n = mid_q;
endmodule

// File: rtl/memcs_decoder_chk.sv
module memcs_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       addr_vld,
  input logic       bus_hold,
  input logic       cfg_low_en,
  input logic       cfg_dram_en,
  input logic       rfsh_req,
  input logic       low_sel_n,
  input logic [3:0] mid_sel_n
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (low_sel_n && (&mid_sel_n))); // R1

  AST_HOLD_GATES: assert property (@(posedge clk) disable iff (rst)
    $past(bus_hold) |-> (low_sel_n && (&mid_sel_n[2:0]))); // R6

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(addr_vld) |-> (low_sel_n && (&mid_sel_n[2:0]))); // R10

  AST_LOW_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_low_en) |-> low_sel_n); // R8

  AST_REFRESH_PIN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_dram_en)) |-> (mid_sel_n[3] == !$past(rfsh_req))); // R7

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~{low_sel_n, mid_sel_n[2:0]})); // R9
endmodule

bind memcs_decoder memcs_decoder_chk u_chk (
  .clk(clk), .rst(rst), .addr_vld(addr_vld), .bus_hold(bus_hold),
  .cfg_low_en(cfg_low_en), .cfg_dram_en(cfg_dram_en), .rfsh_req(rfsh_req),
  .low_sel_n(low_sel_n), .mid_sel_n(mid_sel_n)
);

// File: tb/memcs_decoder_tb_top.sv
module memcs_decoder_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 20;
  localparam int L2_W   = 5;

  typedef struct packed {
    logic              low_en;
    logic [L2_W-1:0]   low_l2;
    logic              mid_en;
    logic [ADDR_W-1:0] mid_base;
    logic [L2_W-1:0]   mid_l2;
    logic              dram;
    logic [ADDR_W-1:0] a;
    logic              vld;
    logic              hold;
    logic              rfsh;
    logic              exp_low;
    logic [3:0]        exp_mid;
    logic [7:0]        req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'd2},  // R2
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h0FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'd2},  // R2
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h10000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd2},  // R2
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h40000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hE, 8'd4},  // R4
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h43FFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'hD, 8'd4},  // R4
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h44010, 1'b1, 1'b0, 1'b0, 1'b1, 4'hB, 8'd4},  // R4
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h47FFF, 1'b1, 1'b0, 1'b0, 1'b1, 4'h7, 8'd4},  // R4
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h48000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd4},  // R4
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h40000, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 8'd10}, // R10
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h00010, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 8'd6},  // R6
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h46000, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 8'd6},  // R6
    '{1'b1, 5'd3,  1'b1, 20'h40000, 5'd15, 1'b0, 20'h003FF, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'd3},  // R3
    '{1'b1, 5'd3,  1'b1, 20'h40000, 5'd15, 1'b0, 20'h00400, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd3},  // R3
    '{1'b1, 5'd25, 1'b0, 20'h40000, 5'd15, 1'b0, 20'h7FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'd3},  // R3
    '{1'b1, 5'd25, 1'b0, 20'h40000, 5'd15, 1'b0, 20'h80000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd3},  // R3
    '{1'b1, 5'd19, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h40000, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'd5},  // R5
    '{1'b0, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h00000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd8},  // R8
    '{1'b1, 5'd16, 1'b0, 20'h40000, 5'd15, 1'b0, 20'h40000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd8},  // R8
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b1, 20'h46000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd7},  // R7
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b1, 20'h10000, 1'b0, 1'b1, 1'b1, 1'b1, 4'h7, 8'd7},  // R7
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b1, 20'h40000, 1'b1, 1'b0, 1'b1, 1'b1, 4'h6, 8'd7},  // R7
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd5,  1'b0, 20'h41800, 1'b1, 1'b0, 1'b0, 1'b1, 4'h7, 8'd3},  // R3
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd5,  1'b0, 20'h42000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'd3},  // R3
    '{1'b1, 5'd16, 1'b1, 20'h80000, 5'd31, 1'b0, 20'hE0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'h7, 8'd3},  // R3
    '{1'b1, 5'd16, 1'b1, 20'h41000, 5'd15, 1'b0, 20'h40000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hE, 8'd4},  // R4
    '{1'b1, 5'd16, 1'b1, 20'h40000, 5'd15, 1'b0, 20'h45000, 1'b1, 1'b0, 1'b0, 1'b1, 4'hB, 8'd4}   // R4
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              addr_vld = 1'b0;
  logic              bus_hold = 1'b0;
  logic              cfg_low_en = 1'b0;
  logic [L2_W-1:0]   cfg_low_size_l2 = '0;
  logic              cfg_mid_en = 1'b0;
  logic [ADDR_W-1:0] cfg_mid_base = '0;
  logic [L2_W-1:0]   cfg_mid_size_l2 = '0;
  logic              cfg_dram_en = 1'b0;
  logic              rfsh_req = 1'b0;
  logic              low_sel_n;
  logic [3:0]        mid_sel_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  memcs_decoder dut_i (
    .clk(clk), .rst(rst), .addr(addr), .addr_vld(addr_vld), .bus_hold(bus_hold),
    .cfg_low_en(cfg_low_en), .cfg_low_size_l2(cfg_low_size_l2),
    .cfg_mid_en(cfg_mid_en), .cfg_mid_base(cfg_mid_base),
    .cfg_mid_size_l2(cfg_mid_size_l2), .cfg_dram_en(cfg_dram_en),
    .rfsh_req(rfsh_req), .low_sel_n(low_sel_n), .mid_sel_n(mid_sel_n)
  );

  task automatic check(input string tag, input logic el, input logic [3:0] em);
    n_run++;
    if (low_sel_n !== el || mid_sel_n !== em) begin
      n_fail++;
      $display("FAIL %s: got low=%b mid=%b expected low=%b mid=%b",
               tag, low_sel_n, mid_sel_n, el, em);
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_low_en      = v.low_en;
    cfg_low_size_l2 = v.low_l2;
    cfg_mid_en      = v.mid_en;
    cfg_mid_base    = v.mid_base;
    cfg_mid_size_l2 = v.mid_l2;
    cfg_dram_en     = v.dram;
    addr            = v.a;
    addr_vld        = v.vld;
    bus_hold        = v.hold;
    rfsh_req        = v.rfsh;
  endtask

  initial begin
    #(CLK_P*20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b1, 4'hF);
    rst = 1'b0;

    // Table walk: drive at a falling edge, sample one falling edge later (R11 latency)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_low, VEC[i].exp_mid);
      n_run++;
      if (!VEC[i].dram && $countones(~{low_sel_n, mid_sel_n}) > 1) begin
        n_fail++;
        $display("FAIL R9 vector %0d: got low=%b mid=%b expected at most one low",
                 i, low_sel_n, mid_sel_n);
      end
    end

    // R11: mid-cycle input change does not move outputs before the next edge
    @(negedge clk);
    apply(VEC[0]);
    @(negedge clk);
    addr = 20'h10000;
    #1;
    check("R11 hold between edges", 1'b0, 4'hF);
    @(negedge clk);
    check("R11 update after edge", 1'b1, 4'hF);

    // R1: reset overrides a live hit and a refresh request in DRAM mode
    apply(VEC[0]);
    cfg_dram_en = 1'b1;
    rfsh_req    = 1'b1;
    @(negedge clk);
    check("R7 before reset", 1'b0, 4'h7);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset overrides", 1'b1, 4'hF);
    @(negedge clk);
    check("R1 reset held", 1'b1, 4'hF);
    rst = 1'b0;
    cfg_dram_en = 1'b0;
    rfsh_req    = 1'b0;
    @(negedge clk);
    check("R2 after reset release", 1'b0, 4'hF);

    // R8: both windows disabled, sweep of addresses
    cfg_low_en = 1'b0;
    cfg_mid_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      addr = ADDR_W'(k * 32'h10000);
      @(negedge clk);
      check("R8 all disabled", 1'b1, 4'hF);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule